// File: doc/BRIEF.md
# Duplicated-Load Bypass Queue

This block sits between a load pipeline and memory, for a core that runs every load twice to detect transient faults. Each load shows up as two copies. A one-bit version tag marks each copy as the original or the duplicate. Only the original reaches memory. Its address is recorded in a queue slot. When memory answers, the returned word is written into that slot and also handed back to the pipeline as the original's response.

The duplicate never touches memory. It is paired with the oldest slot that is still waiting for its partner, and it receives that slot's stored word. At the same time its address is compared with the one the original recorded. The slot is released whether or not the addresses agree. A disagreement sets a fault flag that stays raised until reset. Slots are claimed and released strictly in arrival order, so a duplicate always meets the original that came first.

Top module: `dup_load_queue`

## Requirements
- R1: After reset the fault flag is 0 and no response is presented. The queue is empty, so a duplicate copy is not accepted.
- R2: An original copy (`ld_ver` = 0) is offered to memory in the same cycle with its own address. It is accepted only when memory is ready and the queue is not full.
- R3: Memory read data arrives in request order. One cycle after each `mem_rsp_valid`, a response appears with `rsp_ver` = 0 and the returned word.
- R4: A duplicate copy (`ld_ver` = 1) never raises `mem_req_valid`.
- R5: One cycle after a duplicate is accepted, a response appears with `rsp_ver` = 1. It carries the word stored for its paired original.
- R6: Slots are claimed and released in FIFO order. Each duplicate pairs with the oldest original that has no partner yet.
- R7: A duplicate waits, with `ld_ready` low, while the queue is empty or the oldest slot's memory data has not yet returned.
- R8: In a cycle where `mem_rsp_valid` is high, a duplicate is not accepted, so the single response port is never claimed twice.
- R9: Once DEPTH originals are held without partners, an original copy sees `ld_ready` low.
- R10: A duplicate whose address differs from its original's sets `fault` in the next cycle. `fault` then stays high until reset.
- R11: A mismatching duplicate still releases its slot, so later pairs complete normally.
- R12: A duplicate whose address matches leaves `fault` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load copy presented |
| ld_ver | input | 1 | Copy version: 0 original, 1 duplicate |
| ld_addr | input | AW | Load address |
| ld_ready | output | 1 | Load copy accepted this cycle when high with ld_valid |
| rsp_valid | output | 1 | Load response present |
| rsp_ver | output | 1 | Version of the copy being answered |
| rsp_data | output | DW | Load value |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Memory read data present, in request order |
| mem_rsp_data | input | DW | Memory read data |
| fault | output | 1 | Sticky address-mismatch flag |

## Verification
A memory return and a duplicate bypass both want the one response port, and they can line up in the same cycle. The bench provokes this by issuing two originals back to back with a long memory latency, then presenting the first duplicate at once. That duplicate waits until the first slot fills. In the very next cycle the second slot's data returns. On every such cycle the bench requires `ld_ready` to be low for the waiting duplicate. It also checks that the collision actually happened, and that the scoreboard later receives both responses intact and in an order where each duplicate follows its original.

// File: rtl/dlq_pkg.sv
// Package: shared constants for the duplicated-load bypass queue.
// Assumes: one version bit per load copy; 0 marks the copy that reads memory.
package dlq_pkg;
    localparam logic VER_ORIG = 1'b0;
    localparam logic VER_DUP  = 1'b1;
endpackage

// File: rtl/dlq_ring.sv
// Module: circular slot store with separate claim, fill and release pointers.
// Assumes: alloc never asserted when full; fill only for a claimed, unfilled
// slot (memory answers in order); free only when the head slot is filled.
module dlq_ring #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [AW-1:0] alloc_addr,
    input  logic          fill,
    input  logic [DW-1:0] fill_data,
    input  logic          free,
    output logic          full,
    output logic          empty,
    output logic          head_ready,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];
    logic [DEPTH-1:0] slot_dv;
    logic [PW-1:0] wr_ptr, fl_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Slot contents: claim records the address, fill records data, release clears.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                slot_addr[i] <= '0;
                slot_data[i] <= '0;
                slot_dv[i]   <= 1'b0;
            end else begin
                if (alloc && wr_ptr == PW'(i)) begin
                    slot_addr[i] <= alloc_addr;
                    slot_dv[i]   <= 1'b0;
                end
                if (fill && fl_ptr == PW'(i)) begin
                    slot_data[i] <= fill_data;
                    slot_dv[i]   <= 1'b1;
                end
                if (free && rd_ptr == PW'(i)) begin
                    slot_dv[i] <= 1'b0;
                end
            end
        end
    end

    // Pointer and occupancy bookkeeping in FIFO order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fl_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (alloc) wr_ptr <= step(wr_ptr);
            if (fill)  fl_ptr <= step(fl_ptr);
            if (free)  rd_ptr <= step(rd_ptr);
            count <= count + CW'(alloc) - CW'(free);
        end
    end

    // Head view and occupancy flags.
    always_comb begin
        full       = (count == CW'(DEPTH));
        empty      = (count == '0);
        head_ready = slot_dv[rd_ptr] && !empty;
        head_addr  = slot_addr[rd_ptr];
        head_data  = slot_data[rd_ptr];
    end

    p_alloc_not_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_free_filled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        free |-> slot_dv[rd_ptr]);
    p_fill_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> (!empty && !slot_dv[fl_ptr]));
endmodule

// File: rtl/dlq_match.sv
// Module: response register and address comparator with sticky fault.
// Assumes: fill and take_dup are never high together (the top stalls the
// duplicate on a memory return).
module dlq_match #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill,
    input  logic [DW-1:0] fill_data,
    input  logic          take_dup,
    input  logic [AW-1:0] dup_addr,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    output logic          rsp_valid,
    output logic          rsp_ver,
    output logic [DW-1:0] rsp_data,
    output logic          fault
);
    import dlq_pkg::*;

    logic mismatch;

    // Address comparison for the duplicate being served.
    always_comb mismatch = take_dup && (dup_addr != head_addr);

    // Registered response: memory return for originals, bypass for duplicates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ver   <= VER_ORIG;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fill || take_dup;
            rsp_ver   <= take_dup ? VER_DUP : VER_ORIG;
            rsp_data  <= take_dup ? head_data : fill_data;
        end
    end

    // Sticky fault flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) fault <= 1'b0;
        else        fault <= fault || mismatch;
    end

    p_one_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill && take_dup));
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
    p_match_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (take_dup && dup_addr == head_addr && !fault) |=> !fault);
endmodule

// File: rtl/dup_load_queue.sv
// Module: top of the duplicated-load bypass queue.
// Originals read memory and claim a slot. Duplicates are served from the
// oldest filled slot, and their addresses are compared with the recorded one.
// Assumes: memory answers reads in request order, one per cycle at most.
module dup_load_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic          ld_ver,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_ready,
    output logic          rsp_valid,
    output logic          rsp_ver,
    output logic [DW-1:0] rsp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          fault
);
    import dlq_pkg::*;

    logic full, empty, head_ready;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic orig_req, dup_req, dup_ok, alloc, take_dup;

    // Handshake steering: originals to memory, duplicates to the bypass.
    always_comb begin
        orig_req      = ld_valid && (ld_ver == VER_ORIG);
        dup_req       = ld_valid && (ld_ver == VER_DUP);
        mem_req_valid = orig_req && !full;
        mem_req_addr  = ld_addr;
        alloc         = mem_req_valid && mem_req_ready;
        dup_ok        = head_ready && !mem_rsp_valid;
        take_dup      = dup_req && dup_ok;
        ld_ready      = (ld_ver == VER_DUP) ? dup_ok : (!full && mem_req_ready);
    end

    dlq_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc),
        .alloc_addr (ld_addr),
        .fill       (mem_rsp_valid),
        .fill_data  (mem_rsp_data),
        .free       (take_dup),
        .full       (full),
        .empty      (empty),
        .head_ready (head_ready),
        .head_addr  (head_addr),
        .head_data  (head_data)
    );

    dlq_match #(.AW(AW), .DW(DW)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      (mem_rsp_valid),
        .fill_data (mem_rsp_data),
        .take_dup  (take_dup),
        .dup_addr  (ld_addr),
        .head_addr (head_addr),
        .head_data (head_data),
        .rsp_valid (rsp_valid),
        .rsp_ver   (rsp_ver),
        .rsp_data  (rsp_data),
        .fault     (fault)
    );

    p_dup_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ver == VER_DUP) |-> !mem_req_valid);
    p_dup_wait_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !take_dup);
endmodule

// File: tb/tb_dup_load_queue.sv
// Scoreboard bench: the driver task records expected responses per version,
// and a monitor process pops and compares them as responses appear.
module tb_dup_load_queue;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid = 1'b0;
    logic ld_ver = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic ld_ready, rsp_valid, rsp_ver, mem_req_valid, fault;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] mem_req_addr;
    logic mem_req_ready = 1'b1;
    logic mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    int checks = 0, errors = 0, cyc = 0, mem_lat = 2;
    int collisions = 0, orig_seen = 0, dup_seen = 0;
    logic [AW-1:0] pend_a[$];
    int pend_t[$];
    logic [DW-1:0] exp_o[$], exp_d[$];
    logic [AW-1:0] pair_q[$];
    logic [AW-1:0] mem_a;

    always #(CLK_PERIOD/2) clk = ~clk;

    dup_load_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ver(ld_ver),
        .ld_addr(ld_addr), .ld_ready(ld_ready), .rsp_valid(rsp_valid),
        .rsp_ver(rsp_ver), .rsp_data(rsp_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .fault(fault)
    );

    function automatic logic [DW-1:0] mval(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, a + 16'd7};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: in-order answers after mem_lat cycles, one per cycle.
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rst_n && pend_a.size() > 0 && (cyc - pend_t[0]) >= mem_lat) begin
            mem_a = pend_a.pop_front();
            void'(pend_t.pop_front());
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mval(mem_a);
        end
    end

    // Monitor: compare each response against the queue for its version.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (rsp_ver == 1'b0) begin
                if (exp_o.size() == 0) chk(0, "R3 unexpected original rsp", rsp_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_o.pop_front();
                    chk(rsp_data == e, "R3 original data", rsp_data, e);
                end
                orig_seen++;
            end else begin
                if (exp_d.size() == 0) chk(0, "R5 unexpected duplicate rsp", rsp_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_d.pop_front();
                    chk(rsp_data == e, "R5 R6 duplicate bypass data", rsp_data, e);
                end
                chk(orig_seen > dup_seen, "R7 duplicate before its data", dup_seen, orig_seen);
                dup_seen++;
            end
        end
    end

    task automatic send(input logic ver, input logic [AW-1:0] a);
        logic [AW-1:0] oa;
        @(negedge clk);
        ld_valid = 1'b1; ld_ver = ver; ld_addr = a;
        forever begin
            #(CLK_PERIOD/4);
            if (ver) chk(!mem_req_valid, "R4 duplicate reached memory", mem_req_valid, 0);
            if (ver && mem_rsp_valid) begin
                chk(!ld_ready, "R8 duplicate taken on memory return", ld_ready, 0);
                collisions++;
            end
            if (ld_ready) break;
            @(negedge clk);
        end
        if (!ver) chk(mem_req_valid && mem_req_addr == a, "R2 original forwarded", mem_req_addr, a);
        @(posedge clk);
        if (!ver) begin
            pend_a.push_back(a); pend_t.push_back(cyc);
            exp_o.push_back(mval(a)); pair_q.push_back(a);
        end else begin
            oa = pair_q.pop_front();
            exp_d.push_back(mval(oa));
        end
    endtask

    task automatic probe(input logic ver, input logic [AW-1:0] a, input logic exp_rdy, input string req);
        @(negedge clk);
        ld_valid = 1'b1; ld_ver = ver; ld_addr = a;
        #(CLK_PERIOD/4);
        chk(ld_ready == exp_rdy, req, ld_ready, exp_rdy);
        ld_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk); ld_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ld_valid = 1'b0;
        pend_a.delete(); pend_t.delete(); exp_o.delete(); exp_d.delete(); pair_q.delete();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        #(CLK_PERIOD/4);
        chk(fault == 1'b0, "R1 fault after reset", fault, 0);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1 no memory request when idle", mem_req_valid, 0);
        probe(1'b1, 16'h0010, 1'b0, "R1 R7 duplicate on empty queue");

        // Simple pair: duplicate presented at once, stalls until data lands.
        mem_lat = 2;
        send(1'b0, 16'h1234);
        send(1'b1, 16'h1234);
        idle(4);
        chk(fault == 1'b0, "R12 matching pair keeps fault low", fault, 0);

        // Fill the queue, confirm back-pressure on originals, then drain in order.
        mem_lat = 3;
        for (int i = 0; i < DEPTH; i++) send(1'b0, 16'h2000 + 16'(i));
        idle(6);
        probe(1'b0, 16'h2FFF, 1'b0, "R9 original while full");
        for (int i = 0; i < DEPTH; i++) send(1'b1, 16'h2000 + 16'(i));
        send(1'b0, 16'h2FFF);
        send(1'b1, 16'h2FFF);
        idle(5);

        // Collision: second fill lands the cycle after the head fills.
        mem_lat = 4;
        send(1'b0, 16'h3000);
        send(1'b0, 16'h3001);
        send(1'b1, 16'h3000);
        send(1'b1, 16'h3001);
        idle(6);
        chk(collisions > 0, "R8 memory return met waiting duplicate", collisions, 1);
        chk(fault == 1'b0, "R12 no fault after matching pairs", fault, 0);

        // Mismatch: fault rises, slot still freed, later pairs still served.
        mem_lat = 1;
        send(1'b0, 16'h4000);
        send(1'b1, 16'h4001);
        #(CLK_PERIOD/4);
        chk(fault == 1'b1, "R10 fault after address mismatch", fault, 1);
        idle(3);
        probe(1'b1, 16'h4000, 1'b0, "R11 mismatched slot released");
        send(1'b0, 16'h5000);
        send(1'b1, 16'h5000);
        idle(5);
        chk(fault == 1'b1, "R10 fault sticky over later pairs", fault, 1);
        chk(exp_o.size() == 0, "R3 all original responses seen", exp_o.size(), 0);
        chk(exp_d.size() == 0, "R5 R11 all duplicate responses seen", exp_d.size(), 0);

        do_reset();
        #(CLK_PERIOD/4);
        chk(fault == 1'b0, "R10 fault cleared by reset", fault, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule